// File: doc/BRIEF.md
# Reference Switching Controller with Guard Time

This controller picks the timing reference for a synchronizer fed by two independent line references, a primary and a secondary. It watches a loss-of-signal flag for each reference. It also watches a guard-time level, produced outside the block by a timing network, and an 8 kHz frame pulse. From these it settles on one of five operating states:
- primary normal
- primary holdover
- secondary normal
- secondary holdover
- freerun

The outputs encode that state. A one-cycle request also tells the downstream loop to re-align its phase error whenever it begins tracking a reference again, so that output phase stays continuous.

The block never moves straight from the primary to the secondary. A lost primary first sends it into primary holdover. It stays there until the guard-time level, captured only on a frame-pulse rising edge, says the guard interval has expired. If the primary comes back sooner, the block returns to it and the secondary is never used.

A manual control method lets a host force any state with a three-bit code. In that method the loss flags are ignored. A reset must follow any change of control method.

Top module: `refSwitchCtrl`

## Requirements
- R1: While `rstN` is low and after it is released, the state is freerun: `freerunInd`=1, `holdoverInd`=0, `refSel`=0, `realignPulse`=0. It stays there in automatic mode while both references are lost.
- R2: In automatic mode, freerun moves to primary normal when the primary is present. It moves to secondary normal when only the secondary is present.
- R3: In automatic mode, loss of the primary while in primary normal always leads to primary holdover, never directly to the secondary.
- R4: The guard-time input is captured only on a rising edge of the frame pulse. Changes between frame edges do not alter the automatic transitions.
- R5: In primary holdover with the primary still lost, a captured guard level of 1 and a present secondary move the block to secondary normal. A captured level of 0 keeps it in primary holdover.
- R6: In primary holdover, recovery of the primary returns the block to primary normal.
- R7: In secondary normal, recovery of the primary returns to primary normal. If the primary stays lost and the secondary is lost, the block goes to secondary holdover. In secondary holdover, recovery of the secondary alone returns to secondary normal.
- R8: In automatic mode, loss of both references in any non-freerun state leads to or stays in a holdover state, never freerun.
- R9: In manual mode (`manualEn`=1) the state follows `modeCode` and the loss flags are ignored. The codes are: 000 primary normal, 001 secondary normal, 010 primary holdover, 011 secondary holdover, any code with bit 2 set is freerun.
- R10: `realignPulse` is high for exactly the first cycle of a normal state entered from any other state.
- R11: The outputs encode the state as follows. `refSel`=1 for the two secondary states. `holdoverInd`=1 for the two holdover states. `freerunInd`=1 only in freerun.
- R12: Each input passes through a two-flop synchronizer. A change applied before clock edge k first shows at the outputs after edge k+2. A captured guard level first takes effect one edge after the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameIn | input | 1 | 8 kHz frame pulse, asynchronous |
| primLoss | input | 1 | Primary reference lost, active high |
| secLoss | input | 1 | Secondary reference lost, active high |
| guardIn | input | 1 | Guard-time level: 1 means the guard interval has expired |
| manualEn | input | 1 | 1 selects manual control through `modeCode` |
| modeCode | input | CODE_W | Manual state code |
| refSel | output | 1 | 0 selects primary, 1 selects secondary |
| holdoverInd | output | 1 | Holdover indication |
| freerunInd | output | 1 | Freerun indication |
| realignPulse | output | 1 | One-cycle phase re-alignment request |

## Verification
The automatic machine is driven through the following cases:
- A primary outage that ends before any guard capture, which separates return-to-primary (R6) from a premature secondary switch.
- An outage where the guard level is raised but no frame edge arrives, which separates edge-only capture (R4) from level sampling.
- A captured guard expiry, which exercises the holdover-to-secondary path (R5) and the later drop back to the primary (R7).
- Double-loss patterns from secondary normal and from primary normal, which show that holdover is held instead of falling to freerun.

Manual codes are stepped while the loss flags toggle, which shows that the flags are ignored in that method. Pulse placement and the exact three-edge latency are compared against a behavioural model on every cycle.

// File: rtl/refSwitchPkg.sv
package refSwitchPkg;
  typedef enum logic [2:0] {
    ST_FREE     = 3'd0,
    ST_PRI_NORM = 3'd1,
    ST_PRI_HOLD = 3'd2,
    ST_SEC_NORM = 3'd3,
    ST_SEC_HOLD = 3'd4
  } refStateE;

  // strobes from control to the output stage
  typedef struct packed {
    logic selSec;
    logic hold;
    logic free;
    logic realign;
  } ctlStrobeT;
endpackage

// File: rtl/refSwitchSyncCell.sv
module refSwitchSyncCell #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/refSwitchPath.sv
module refSwitchPath
  import refSwitchPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameIn,
  input  logic              primLoss,
  input  logic              secLoss,
  input  logic              guardIn,
  input  logic              manualEn,
  input  logic [CODE_W-1:0] modeCode,
  input  ctlStrobeT         ctl,
  output logic              primLossS,
  output logic              secLossS,
  output logic              manualS,
  output logic [CODE_W-1:0] modeS,
  output logic              guardS,
  output logic              frameStrobe,
  output logic              refSel,
  output logic              holdoverInd,
  output logic              freerunInd,
  output logic              realignPulse
);
  localparam int LOSS_W = 2;
  localparam int MISC_W = 3;

  logic [LOSS_W-1:0] lossSync;
  logic [MISC_W-1:0] miscSync;
  logic frameS, guardLvl, framePrev;

  // loss flags come up as "lost" out of reset
  refSwitchSyncCell #(.WIDTH(LOSS_W), .STAGES(SYNC_STAGES), .RST_VAL({LOSS_W{1'b1}})) uLoss (
    .clk(clk), .rstN(rstN), .din({primLoss, secLoss}), .dout(lossSync));

  refSwitchSyncCell #(.WIDTH(MISC_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) uMisc (
    .clk(clk), .rstN(rstN), .din({frameIn, guardIn, manualEn}), .dout(miscSync));

  refSwitchSyncCell #(.WIDTH(CODE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) uCode (
    .clk(clk), .rstN(rstN), .din(modeCode), .dout(modeS));

  assign {primLossS, secLossS} = lossSync;
  assign {frameS, guardLvl, manualS} = miscSync;
  assign frameStrobe = frameS & ~framePrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      framePrev <= 1'b0;
      guardS    <= 1'b0;
    end else begin
      framePrev <= frameS;
      if (frameStrobe) guardS <= guardLvl;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refSel       <= 1'b0;
      holdoverInd  <= 1'b0;
      freerunInd   <= 1'b1;
      realignPulse <= 1'b0;
    end else begin
      refSel       <= ctl.selSec;
      holdoverInd  <= ctl.hold;
      freerunInd   <= ctl.free;
      realignPulse <= ctl.realign;
    end
  end
endmodule

// File: rtl/refSwitchFsm.sv
module refSwitchFsm
  import refSwitchPkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              primLossS,
  input  logic              secLossS,
  input  logic              guardS,
  input  logic              manualS,
  input  logic [CODE_W-1:0] modeS,
  output ctlStrobeT         ctl
);
  localparam int SEL_W = 2;

  refStateE curState, nxtState, manState;
  logic [SEL_W-1:0] lowCode;

  assign lowCode = modeS[SEL_W-1:0];

  always_comb begin
    if (|modeS[CODE_W-1:SEL_W]) manState = ST_FREE;
    else begin
      case (lowCode)
        2'b00:   manState = ST_PRI_NORM;
        2'b01:   manState = ST_SEC_NORM;
        2'b10:   manState = ST_PRI_HOLD;
        default: manState = ST_SEC_HOLD;
      endcase
    end
  end

  always_comb begin
    nxtState = curState;
    if (manualS) nxtState = manState;
    else begin
      case (curState)
        ST_FREE: begin
          if (!primLossS) nxtState = ST_PRI_NORM;
          else if (!secLossS) nxtState = ST_SEC_NORM;
        end
        ST_PRI_NORM: begin
          if (primLossS) nxtState = ST_PRI_HOLD;
        end
        ST_PRI_HOLD: begin
          if (!primLossS) nxtState = ST_PRI_NORM;
          else if (guardS && !secLossS) nxtState = ST_SEC_NORM;
        end
        ST_SEC_NORM: begin
          if (!primLossS) nxtState = ST_PRI_NORM;
          else if (secLossS) nxtState = ST_SEC_HOLD;
        end
        ST_SEC_HOLD: begin
          if (!primLossS) nxtState = ST_PRI_NORM;
          else if (!secLossS) nxtState = ST_SEC_NORM;
        end
        default: nxtState = ST_FREE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_FREE;
    else       curState <= nxtState;
  end

  always_comb begin
    ctl.selSec  = (nxtState == ST_SEC_NORM) || (nxtState == ST_SEC_HOLD);
    ctl.hold    = (nxtState == ST_PRI_HOLD) || (nxtState == ST_SEC_HOLD);
    ctl.free    = (nxtState == ST_FREE);
    ctl.realign = ((nxtState == ST_PRI_NORM) || (nxtState == ST_SEC_NORM))
                  && (nxtState != curState);
  end
endmodule

// File: rtl/refSwitchCtrl.sv
module refSwitchCtrl
  import refSwitchPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameIn,
  input  logic              primLoss,
  input  logic              secLoss,
  input  logic              guardIn,
  input  logic              manualEn,
  input  logic [CODE_W-1:0] modeCode,
  output logic              refSel,
  output logic              holdoverInd,
  output logic              freerunInd,
  output logic              realignPulse
);
  ctlStrobeT ctl;
  logic primLossS, secLossS, manualS, guardS, frameStrobe;
  logic [CODE_W-1:0] modeS;

  refSwitchPath #(.SYNC_STAGES(SYNC_STAGES), .CODE_W(CODE_W)) uPath (
    .clk(clk), .rstN(rstN), .frameIn(frameIn), .primLoss(primLoss),
    .secLoss(secLoss), .guardIn(guardIn), .manualEn(manualEn),
    .modeCode(modeCode), .ctl(ctl), .primLossS(primLossS),
    .secLossS(secLossS), .manualS(manualS), .modeS(modeS), .guardS(guardS),
    .frameStrobe(frameStrobe), .refSel(refSel), .holdoverInd(holdoverInd),
    .freerunInd(freerunInd), .realignPulse(realignPulse));

  refSwitchFsm #(.CODE_W(CODE_W)) uFsm (
    .clk(clk), .rstN(rstN), .primLossS(primLossS), .secLossS(secLossS),
    .guardS(guardS), .manualS(manualS), .modeS(modeS), .ctl(ctl));
endmodule

// File: rtl/refSwitchCheck.sv
module refSwitchCheck (
  input logic clk,
  input logic rstN,
  input logic refSel,
  input logic holdoverInd,
  input logic freerunInd,
  input logic realignPulse,
  input logic manualS,
  input logic guardS,
  input logic frameStrobe
);
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assert_pn_no_direct_sec_R3: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (!manualS && !refSel && !holdoverInd && !freerunInd) |=> !refSel);

  assert_guard_edge_only_R4: assert property (@(posedge clk) disable iff (!rstN || !armed)
    !frameStrobe |=> $stable(guardS));

  assert_hold_needs_guard_R5: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (!manualS && holdoverInd && !refSel && !guardS) |=> !(refSel && !holdoverInd));

  assert_auto_no_freerun_R8: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (!manualS && !freerunInd) |=> !freerunInd);

  assert_pulse_in_normal_R10: assert property (@(posedge clk) disable iff (!rstN || !armed)
    realignPulse |-> (!holdoverInd && !freerunInd));

  assert_pulse_on_change_R10: assert property (@(posedge clk) disable iff (!rstN || !armed)
    realignPulse |-> (refSel != $past(refSel) || $past(holdoverInd) || $past(freerunInd)));

  assert_indicator_excl_R11: assert property (@(posedge clk) disable iff (!rstN || !armed)
    !(freerunInd && (holdoverInd || refSel)));
endmodule

bind refSwitchCtrl refSwitchCheck uCheck (
  .clk(clk), .rstN(rstN), .refSel(refSel), .holdoverInd(holdoverInd),
  .freerunInd(freerunInd), .realignPulse(realignPulse), .manualS(manualS),
  .guardS(guardS), .frameStrobe(frameStrobe));

// File: tb/tb_refSwitchCtrl.sv
module tb_refSwitchCtrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameIn = 1'b0, primLoss = 1'b1, secLoss = 1'b1, guardIn = 1'b0, manualEn = 1'b0;
  logic [2:0] modeCode = 3'b000;
  logic refSel, holdoverInd, freerunInd, realignPulse;

  int vecCount = 0;
  int failCount = 0;
  string curReq = "R1";
  bit finished = 1'b0;

  // model: 0 freerun, 1 prim normal, 2 prim hold, 3 sec normal, 4 sec hold
  int mState = 0;
  bit mPulse = 1'b0, mGuard = 1'b0;
  bit pl1, pl2, sl1, sl2, gd1, gd2, fr1, fr2, fr3, mn1, mn2;
  logic [2:0] mc1, mc2;

  always #10 clk = ~clk;

  refSwitchCtrl dut (
    .clk(clk), .rstN(rstN), .frameIn(frameIn), .primLoss(primLoss),
    .secLoss(secLoss), .guardIn(guardIn), .manualEn(manualEn),
    .modeCode(modeCode), .refSel(refSel), .holdoverInd(holdoverInd),
    .freerunInd(freerunInd), .realignPulse(realignPulse));

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mPulse = 0; mGuard = 0;
      pl1 = 1; pl2 = 1; sl1 = 1; sl2 = 1;
      gd1 = 0; gd2 = 0; fr1 = 0; fr2 = 0; fr3 = 0; mn1 = 0; mn2 = 0;
      mc1 = 0; mc2 = 0;
    end else begin
      int nxt;
      nxt = mState;
      if (mn2) begin
        if (mc2[2]) nxt = 0;
        else if (mc2[1:0] == 2'd0) nxt = 1;
        else if (mc2[1:0] == 2'd1) nxt = 3;
        else if (mc2[1:0] == 2'd2) nxt = 2;
        else nxt = 4;
      end else begin
        if (mState == 0) nxt = !pl2 ? 1 : (!sl2 ? 3 : 0);
        else if (!pl2) nxt = 1;
        else if (mState == 1) nxt = 2;
        else if (mState == 2) nxt = (mGuard && !sl2) ? 3 : 2;
        else nxt = sl2 ? 4 : 3;
      end
      mPulse = (nxt == 1 || nxt == 3) && (nxt != mState);
      mState = nxt;
      if (fr2 && !fr3) mGuard = gd2;
      fr3 = fr2; fr2 = fr1; fr1 = frameIn;
      pl2 = pl1; pl1 = primLoss; sl2 = sl1; sl1 = secLoss;
      gd2 = gd1; gd1 = guardIn; mn2 = mn1; mn1 = manualEn;
      mc2 = mc1; mc1 = modeCode;
    end
  end

  function automatic logic [3:0] encode(int st, bit pulse);
    return {(st == 3 || st == 4), (st == 2 || st == 4), (st == 0), pulse};
  endfunction

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (!finished) begin
      logic [3:0] act, exp;
      act = {refSel, holdoverInd, freerunInd, realignPulse};
      exp = encode(mState, mPulse);
      vecCount++;
      if (act !== exp) begin
        failCount++;
        $display("FAIL %s model compare: got %b expected %b (sel,hold,free,pulse)", curReq, act, exp);
      end
    end
  end

  // directed check against a fixed expected state
  task automatic chk(string req, int st, bit pulse);
    logic [3:0] act, exp;
    act = {refSel, holdoverInd, freerunInd, realignPulse};
    exp = encode(st, pulse);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s directed: got %b expected %b (sel,hold,free,pulse)", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frameEdge();
    frameIn = 1'b1; step(3); frameIn = 1'b0; step(3);
  endtask

  initial begin
    step(3);
    curReq = "R1"; chk("R1", 0, 0);
    rstN = 1'b1;
    step(6); chk("R1", 0, 0);

    // freerun to primary normal, latency three edges
    curReq = "R12"; primLoss = 1'b0;
    step(2); chk("R12", 0, 0);
    step(1); chk("R2", 1, 1);
    step(1); chk("R10", 1, 0);

    // primary lost, guard raised without a frame edge
    curReq = "R4"; guardIn = 1'b1; secLoss = 1'b0; step(4);
    primLoss = 1'b1; step(3); chk("R3", 2, 0);
    step(12); chk("R4", 2, 0);

    // primary returns before guard capture
    curReq = "R6"; primLoss = 1'b0; step(3); chk("R6", 1, 1);
    step(2); primLoss = 1'b1; guardIn = 1'b0; step(5);
    frameEdge(); step(8); chk("R5", 2, 0);

    // guard capture takes the block to the secondary
    curReq = "R5"; guardIn = 1'b1; step(2);
    frameIn = 1'b1; step(3); chk("R12", 2, 0);
    step(1); chk("R5", 3, 1);
    frameIn = 1'b0; step(4);

    // secondary lost, then both lost for a while
    curReq = "R7"; secLoss = 1'b1; step(3); chk("R7", 4, 0);
    curReq = "R8"; step(20); chk("R8", 4, 0);
    curReq = "R7"; secLoss = 1'b0; step(3); chk("R7", 3, 1);
    primLoss = 1'b0; step(3); chk("R7", 1, 1);

    // double loss from primary normal holds
    curReq = "R8"; primLoss = 1'b1; secLoss = 1'b1; step(30); chk("R8", 2, 0);
    secLoss = 1'b0; step(3); chk("R5", 3, 1);

    // manual codes while the flags toggle
    curReq = "R9"; manualEn = 1'b1; modeCode = 3'b010; step(4); chk("R9", 2, 0);
    primLoss = 1'b0; secLoss = 1'b1; step(5); chk("R9", 2, 0);
    modeCode = 3'b000; step(3); chk("R10", 1, 1);
    modeCode = 3'b001; step(3); chk("R9", 3, 1);
    modeCode = 3'b011; primLoss = 1'b1; step(4); chk("R9", 4, 0);
    modeCode = 3'b100; step(4); chk("R9", 0, 0);
    modeCode = 3'b111; secLoss = 1'b0; step(4); chk("R11", 0, 0);
    modeCode = 3'b001; step(3); chk("R11", 3, 1);

    // back to automatic from secondary normal, primary still lost
    curReq = "R2"; manualEn = 1'b0; step(5); chk("R2", 3, 0);
    primLoss = 1'b0; step(4); chk("R7", 1, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: got timeout expected completion");
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule